// File: doc/BRIEF.md
# Vernier Coincidence Time-to-Digital Controller

This block is the digital control for a vernier time-to-digital converter. A free-running coarse counter runs on the reference clock. When an event is accepted, the block stores the coarse count and enables an external triggered oscillator. That oscillator's period is shorter than the reference period by a fixed step. On every later reference clock, the gap between an oscillator edge and the next reference edge therefore shrinks by one step.

An external detector raises a coincidence input when the two clocks switch together. The block counts the reference clocks from acceptance up to that point. Multiplied by the step, this count is the fractional part of the timestamp in picoseconds.

The result comes out as an integer count and a fraction, marked by a one-cycle valid strobe. A measurement that finds no coincidence within one reference period's worth of steps ends with an error flag. Events that arrive while a measurement is running are dropped and recorded. The event input is a single-cycle pulse that is already synchronous to the reference clock.

Top module: `vernier_tdc_ctrl`

## Requirements
- R1: After synchronous reset, osc_en_o, res_valid_o, err_o and overrun_o are 0, and res_int_o, res_frac_o and overrun_cnt_o are 0.
- R2: An event_i pulse seen while idle is accepted: osc_en_o reads 1 after that clock edge, err_o reads 0, and a measurement is in progress.
- R3: The coarse counter clears on reset, adds 1 on every clock and wraps at CNT_W bits. res_int_o equals the counter value in the cycle the event was accepted.
- R4: If coin_i is high in the k-th cycle after acceptance (k from 1 to MAX_SLIP = REF_PERIOD_PS/DELTA_PS), then res_frac_o equals k*DELTA_PS.
- R5: The coincidence edge raises res_valid_o for exactly one cycle and clears osc_en_o at the same edge.
- R6: If coin_i stays low through the MAX_SLIP-th cycle, then after that edge err_o is 1, osc_en_o is 0 and no valid strobe is produced. err_o holds until the next accepted event.
- R7: An event_i pulse during a measurement, including in the coincidence cycle, is ignored: the result is unchanged and overrun_o goes to 1 and stays there until reset.
- R8: overrun_cnt_o counts ignored events and saturates at 2^OVR_W-1.
- R9: coin_i while idle has no effect: res_valid_o and osc_en_o stay 0.
- R10: An event in the cycle right after a valid strobe is accepted as a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| event_i | input | 1 | Synchronous event pulse |
| coin_i | input | 1 | Coincidence report from the external detector |
| osc_en_o | output | 1 | Enable for the triggered oscillator |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_int_o | output | CNT_W | Coarse count at the event |
| res_frac_o | output | FRAC_W | Fraction in picoseconds |
| err_o | output | 1 | No coincidence within the slip window |
| overrun_o | output | 1 | Sticky flag for ignored events |
| overrun_cnt_o | output | OVR_W | Saturating count of ignored events |

## Verification
The hardest cases to reach from the ports are the window edges, together with an event that lands in the same cycle as the coincidence. In that cycle the block must finish the current result and drop the new event.

The bench models the oscillator and detector by hand. It drives coin_i in a chosen slip cycle, which can be the first, the last, or never. It can also inject an event in any chosen cycle of the measurement, including the coincidence cycle.

Randomly drawn slip counts, injection points and timeouts are mixed with directed runs. These runs start a measurement straight after a strobe and push the overrun counter past saturation.

// File: rtl/vtdc_pkg.sv
package vtdc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_MEAS = 1'b1
  } vtdc_state_e;

endpackage

// File: rtl/vtdc_coarse_ctr.sv
module vtdc_coarse_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count_o
);

  always_ff @(posedge clk) begin
    if (rst) count_o <= '0;
    else     count_o <= count_o + 1'b1;
  end

endmodule

// File: rtl/vtdc_slip_ctrl.sv
module vtdc_slip_ctrl
  import vtdc_pkg::*;
#(
  parameter int MAX_SLIP = 50,
  parameter int SLIP_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              event_i,
  input  logic              coin_i,
  output logic              osc_en_o,
  output logic              busy_o,
  output logic              start_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [SLIP_W-1:0] slip_o
);

  localparam logic [SLIP_W-1:0] SLIP_LAST = SLIP_W'(MAX_SLIP);

  vtdc_state_e state_q;
  logic [SLIP_W-1:0] slip_q;
  logic osc_q;
  logic at_last;

  assign at_last   = (slip_q == SLIP_LAST);
  assign busy_o    = (state_q == ST_MEAS);
  assign start_o   = (state_q == ST_IDLE) && event_i;
  assign done_o    = busy_o && coin_i;
  assign timeout_o = busy_o && !coin_i && at_last;
  assign slip_o    = slip_q;
  assign osc_en_o  = osc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slip_q  <= '0;
      osc_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (event_i) begin
            state_q <= ST_MEAS;
            slip_q  <= SLIP_W'(1);
            osc_q   <= 1'b1;
          end
        end
        ST_MEAS: begin
          if (coin_i || at_last) begin
            state_q <= ST_IDLE;
            slip_q  <= '0;
            osc_q   <= 1'b0;
          end else begin
            slip_q  <= slip_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          slip_q  <= '0;
          osc_q   <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/vtdc_result.sv
module vtdc_result #(
  parameter int CNT_W    = 16,
  parameter int SLIP_W   = 6,
  parameter int FRAC_W   = 13,
  parameter int DELTA_PS = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              timeout_i,
  input  logic [CNT_W-1:0]  coarse_i,
  input  logic [SLIP_W-1:0] slip_i,
  output logic              valid_o,
  output logic [CNT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              err_o
);

  localparam int PROD_W = SLIP_W + 32;

  logic [CNT_W-1:0]  cap_q;
  logic [PROD_W-1:0] prod;
  logic [FRAC_W-1:0] frac_calc;

  assign prod      = PROD_W'(slip_i) * PROD_W'(DELTA_PS);
  assign frac_calc = prod[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      valid_o <= 1'b0;
      int_o   <= '0;
      frac_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (start_i) begin
        cap_q <= coarse_i;
        err_o <= 1'b0;
      end
      if (done_i) begin
        int_o  <= cap_q;
        frac_o <= frac_calc;
      end
      if (timeout_i) err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/vtdc_overrun.sv
module vtdc_overrun #(
  parameter int OVR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             event_i,
  input  logic             busy_i,
  output logic             flag_o,
  output logic [OVR_W-1:0] count_o
);

  localparam logic [OVR_W-1:0] CNT_MAX = '1;

  logic dropped;
  assign dropped = event_i && busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      count_o <= '0;
    end else if (dropped) begin
      flag_o <= 1'b1;
      if (count_o != CNT_MAX) count_o <= count_o + 1'b1;
    end
  end

endmodule

// File: rtl/vernier_tdc_ctrl.sv
module vernier_tdc_ctrl #(
  parameter int CNT_W         = 16,
  parameter int REF_PERIOD_PS = 5000,
  parameter int DELTA_PS      = 100,
  parameter int OVR_W         = 4,
  localparam int MAX_SLIP     = REF_PERIOD_PS / DELTA_PS,
  localparam int SLIP_W       = $clog2(MAX_SLIP + 1),
  localparam int FRAC_W       = $clog2(REF_PERIOD_PS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              event_i,
  input  logic              coin_i,
  output logic              osc_en_o,
  output logic              res_valid_o,
  output logic [CNT_W-1:0]  res_int_o,
  output logic [FRAC_W-1:0] res_frac_o,
  output logic              err_o,
  output logic              overrun_o,
  output logic [OVR_W-1:0]  overrun_cnt_o
);

  logic [CNT_W-1:0]  coarse;
  logic [SLIP_W-1:0] slip;
  logic busy, start, done, timeout;

  vtdc_coarse_ctr #(.CNT_W(CNT_W)) coarse_i (
    .clk(clk), .rst(rst), .count_o(coarse)
  );

  vtdc_slip_ctrl #(.MAX_SLIP(MAX_SLIP), .SLIP_W(SLIP_W)) ctrl_i (
    .clk(clk), .rst(rst), .event_i(event_i), .coin_i(coin_i),
    .osc_en_o(osc_en_o), .busy_o(busy), .start_o(start),
    .done_o(done), .timeout_o(timeout), .slip_o(slip)
  );

  vtdc_result #(
    .CNT_W(CNT_W), .SLIP_W(SLIP_W), .FRAC_W(FRAC_W), .DELTA_PS(DELTA_PS)
  ) result_i (
    .clk(clk), .rst(rst), .start_i(start), .done_i(done),
    .timeout_i(timeout), .coarse_i(coarse), .slip_i(slip),
    .valid_o(res_valid_o), .int_o(res_int_o), .frac_o(res_frac_o),
    .err_o(err_o)
  );

  vtdc_overrun #(.OVR_W(OVR_W)) ovr_i (
    .clk(clk), .rst(rst), .event_i(event_i), .busy_i(busy),
    .flag_o(overrun_o), .count_o(overrun_cnt_o)
  );

endmodule

// File: rtl/vtdc_checker.sv
module vtdc_checker #(
  parameter int CNT_W         = 16,
  parameter int REF_PERIOD_PS = 5000,
  parameter int DELTA_PS      = 100,
  parameter int OVR_W         = 4,
  parameter int FRAC_W        = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              event_i,
  input logic              coin_i,
  input logic              osc_en_o,
  input logic              res_valid_o,
  input logic [CNT_W-1:0]  res_int_o,
  input logic [FRAC_W-1:0] res_frac_o,
  input logic              err_o,
  input logic              overrun_o,
  input logic [OVR_W-1:0]  overrun_cnt_o
);

  // R2: the oscillator only starts after an event
  a_r2_osc_start_needs_event: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en_o) |-> $past(event_i));

  // R5: strobe lasts one cycle and the oscillator is already off
  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |=> !res_valid_o);
  a_r5_osc_off_at_valid: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> !osc_en_o && $fell(osc_en_o));

  // R4: the fraction is a whole number of steps within one period
  a_r4_frac_range: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (int'(res_frac_o) <= REF_PERIOD_PS) &&
                    (int'(res_frac_o) % DELTA_PS == 0) && (res_frac_o != '0));

  // R6: the error rises only as the oscillator is shut down, with no strobe
  a_r6_err_stops_osc: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> $fell(osc_en_o) && !res_valid_o);

  // R7: the overrun flag is sticky
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  // R8: the overrun count never decreases
  a_r8_ovr_cnt_monotonic: assert property (@(posedge clk) disable iff (rst)
    overrun_cnt_o >= $past(overrun_cnt_o));

  // R9: a strobe needs a measurement that was running
  a_r9_valid_needs_osc: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> $past(osc_en_o));

endmodule

bind vernier_tdc_ctrl vtdc_checker #(
  .CNT_W(CNT_W), .REF_PERIOD_PS(REF_PERIOD_PS), .DELTA_PS(DELTA_PS),
  .OVR_W(OVR_W), .FRAC_W(FRAC_W)
) chk_i (
  .clk(clk), .rst(rst), .event_i(event_i), .coin_i(coin_i),
  .osc_en_o(osc_en_o), .res_valid_o(res_valid_o), .res_int_o(res_int_o),
  .res_frac_o(res_frac_o), .err_o(err_o), .overrun_o(overrun_o),
  .overrun_cnt_o(overrun_cnt_o)
);

// File: tb/vernier_tdc_ctrl_tb_top.sv
`timescale 1ns/1ps
module vernier_tdc_ctrl_tb_top;

  localparam int CNT_W    = 16;
  localparam int REF_PS   = 5000;
  localparam int DELTA    = 100;
  localparam int OVR_W    = 4;
  localparam int MAXS     = REF_PS / DELTA;
  localparam int FRAC_W   = $clog2(REF_PS + 1);
  localparam int OVR_MAX  = (1 << OVR_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic event_i = 1'b0;
  logic coin_i = 1'b0;
  logic osc_en_o, res_valid_o, err_o, overrun_o;
  logic [CNT_W-1:0]  res_int_o;
  logic [FRAC_W-1:0] res_frac_o;
  logic [OVR_W-1:0]  overrun_cnt_o;

  int checks = 0;
  int failures = 0;
  int exp_ovr = 0;
  logic [CNT_W-1:0] mcnt;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) mcnt <= '0;
    else     mcnt <= mcnt + 1'b1;
  end

  vernier_tdc_ctrl #(
    .CNT_W(CNT_W), .REF_PERIOD_PS(REF_PS), .DELTA_PS(DELTA), .OVR_W(OVR_W)
  ) dut_i (
    .clk(clk), .rst(rst), .event_i(event_i), .coin_i(coin_i),
    .osc_en_o(osc_en_o), .res_valid_o(res_valid_o), .res_int_o(res_int_o),
    .res_frac_o(res_frac_o), .err_o(err_o), .overrun_o(overrun_o),
    .overrun_cnt_o(overrun_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_frac(input int k);
    return k * DELTA;
  endfunction

  function automatic int sat_inc(input int v);
    return (v < OVR_MAX) ? v + 1 : v;
  endfunction

  // k: coincidence slip cycle; inj: cycle for a stray event (0 none); to: no coincidence
  task automatic measure(input int k, input int inj, input bit to);
    logic [CNT_W-1:0] exp_int;
    int last;
    @(negedge clk);
    event_i = 1'b1;
    exp_int = mcnt;
    @(posedge clk); #1;
    chk(osc_en_o == 1'b1, "R2 osc_en after accept", int'(osc_en_o), 1);
    chk(err_o == 1'b0, "R6 err cleared by accept", int'(err_o), 0);
    chk(res_valid_o == 1'b0, "R5 valid single cycle", int'(res_valid_o), 0);
    last = to ? MAXS : k;
    for (int c = 1; c <= last; c++) begin
      @(negedge clk);
      coin_i  = (!to && c == k);
      event_i = (c == inj);
      @(posedge clk);
    end
    #1;
    coin_i = 1'b0;
    event_i = 1'b0;
    if (inj != 0) exp_ovr = sat_inc(exp_ovr);
    chk(osc_en_o == 1'b0, "R5 osc_en dropped", int'(osc_en_o), 0);
    if (!to) begin
      chk(res_valid_o == 1'b1, "R5 valid strobe", int'(res_valid_o), 1);
      chk(res_int_o == exp_int, "R3 integer part", int'(res_int_o), int'(exp_int));
      chk(int'(res_frac_o) == exp_frac(k), "R4 fraction", int'(res_frac_o), exp_frac(k));
    end else begin
      chk(res_valid_o == 1'b0, "R6 no strobe on timeout", int'(res_valid_o), 0);
      chk(err_o == 1'b1, "R6 err on timeout", int'(err_o), 1);
    end
    chk(overrun_o == (exp_ovr > 0), "R7 overrun flag", int'(overrun_o), int'(exp_ovr > 0));
    chk(int'(overrun_cnt_o) == exp_ovr, "R8 overrun count", int'(overrun_cnt_o), exp_ovr);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(osc_en_o == 0, "R1 osc_en reset", int'(osc_en_o), 0);
    chk(res_valid_o == 0, "R1 valid reset", int'(res_valid_o), 0);
    chk(err_o == 0, "R1 err reset", int'(err_o), 0);
    chk(overrun_o == 0, "R1 overrun reset", int'(overrun_o), 0);
    chk(overrun_cnt_o == 0, "R1 overrun count reset", int'(overrun_cnt_o), 0);
    chk(res_int_o == 0 && res_frac_o == 0, "R1 result reset", int'(res_int_o), 0);

    // R9: coincidence while idle
    @(negedge clk); coin_i = 1'b1;
    @(posedge clk); #1;
    chk(res_valid_o == 0, "R9 idle coin no valid", int'(res_valid_o), 0);
    chk(osc_en_o == 0, "R9 idle coin no osc", int'(osc_en_o), 0);
    coin_i = 1'b0;

    repeat (5) @(negedge clk);
    measure(1, 0, 0);          // smallest slip
    measure(MAXS, 0, 0);       // R10 back-to-back, largest slip
    measure(0, 0, 1);          // R6 timeout
    repeat (2) @(negedge clk);
    #1;
    chk(err_o == 1'b1, "R6 err held while idle", int'(err_o), 1);
    measure(7, 7, 0);          // R7 stray event in coincidence cycle
    measure(4, 1, 0);          // R7 stray event in first cycle

    for (int i = 0; i < 30; i++) begin
      int k, inj, gap;
      bit to;
      to  = ($urandom % 8) == 0;
      k   = 1 + ($urandom % MAXS);
      inj = (($urandom % 3) == 0) ? 1 + ($urandom % (to ? MAXS : k)) : 0;
      gap = $urandom % 4;
      repeat (gap) @(negedge clk);
      measure(k, inj, to);
    end

    for (int i = 0; i < OVR_MAX + 2; i++) measure(3, 2, 0);  // R8 saturation
    chk(int'(overrun_cnt_o) == OVR_MAX, "R8 saturated", int'(overrun_cnt_o), OVR_MAX);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule